// File: doc/BRIEF.md
# Four-Line TDM B/D Channel Serial Port

This block is the digital side of a time-division multiplexed highway that carries voice/data bytes and signalling bits for four subscriber lines. Every line owns two 8-bit bearer channels and one 2-bit signalling field. An 8 kHz frame pulse and a bit clock set the frame. Bearer data travels on one serial bus pair and signalling data on a second, separate pair. The bit clock is oversampled by the core clock. The time-slot positions are static configuration inputs.

On the transmit path, the block samples the serial inputs on falling bit-clock edges during the slots given to each enabled channel. It collects the bits per channel and presents the completed bytes and fields to the line side at the next frame pulse. On the receive path, the block latches the line-side bytes and fields at the frame pulse. It then shifts them out during their slots on rising bit-clock edges, with an output-enable for each bus. The enable is held low at all other times. An active-low indicator marks every bearer slot that is being driven.

Top module: `tdm_bd_port`

## Requirements
- R1: After reset, `b_oe` and `d_oe` are 0, `b_slot_n` is 1, and `line_tx_b` and `line_tx_d` are all zero.
- R2: Until the first frame pulse has been sampled, the block drives neither bus and captures nothing.
- R3: When `frame_sync` is high at a falling bit-clock edge, the next bit period is bit 0 of a new frame. Any frame length from 32 to 512 bits is followed, and successive frames may differ in length.
- R4: Bearer channel c is line c/2 (c even: first bearer, c odd: second). It uses `b_slot_cfg[8c+7:8c]` = s and `line_rx_b[8c+7:8c]`. When enabled, it drives frame bits 8s to 8s+7 on `b_out`, most significant bit first, launched on rising bit-clock edges, with `b_oe` high.
- R5: `b_slot_n` is 0 exactly while `b_oe` is 1. Outside enabled bearer slots, `b_oe` is 0 and `b_slot_n` is 1.
- R6: For line l with `d_slot_cfg[8l+7:8l]` = s, the field `line_rx_d[2l+1:2l]` is driven on `d_out` at frame bits 2s (bit 1) and 2s+1 (bit 0) with `d_oe` high. Outside these sub-slots, `d_oe` is 0.
- R7: `b_in` is sampled at falling edges in each enabled channel's slot, MSB first, into that channel's byte. The byte appears on `line_tx_b[8c+7:8c]` at the frame pulse that ends the frame, and it changes at no other time.
- R8: `d_in` is captured the same way in each enabled line's sub-slot, high bit first. It appears on `line_tx_d[2l+1:2l]` only at the frame pulse.
- R9: Receive data is taken from `line_rx_b`/`line_rx_d` at the frame pulse. Changes during a frame affect only the following frame.
- R10: When several enabled channels (or lines) share a slot, the lowest-numbered one drives the output. Every one of them captures the input bits.
- R11: A channel whose `b_en` bit (or a line whose `d_en` bit) is 0 never drives, and its `line_tx` field keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock |
| frame_sync | input | 1 | Frame pulse, sampled on falling bit-clock edge |
| b_in | input | 1 | Serial bearer transmit input |
| d_in | input | 1 | Serial signalling transmit input |
| b_slot_cfg | input | 64 | Slot index per bearer channel, 8 bits each |
| b_en | input | 8 | Enable per bearer channel |
| d_slot_cfg | input | 32 | Sub-slot index per line, 8 bits each |
| d_en | input | 4 | Signalling enable per line |
| line_rx_b | input | 64 | Line-side receive bytes per channel |
| line_rx_d | input | 8 | Line-side receive fields per line |
| line_tx_b | output | 64 | Captured transmit bytes per channel |
| line_tx_d | output | 8 | Captured transmit fields per line |
| b_out | output | 1 | Serial bearer receive data |
| b_oe | output | 1 | Bearer output enable (release when 0) |
| b_slot_n | output | 1 | Active-low bearer slot indicator |
| d_out | output | 1 | Serial signalling receive data |
| d_oe | output | 1 | Signalling output enable |

## Verification
The hardest condition to reach is a frame boundary. At that edge the final transmit bit of one frame is captured, the transmit bytes are published, and the receive latch is reloaded, all on the same falling edge. Combined with a change of frame length, it is only observable in the bit positions right after the pulse. The stimulus places active slots in the last and first positions of both a 32-bit and a 256-bit frame. It changes the frame length between consecutive frames and rewrites the line-side receive data halfway through a frame. It also assigns two channels to one slot, so that output priority and shared capture are visible at the ports.

// File: rtl/tdm_pkg.sv
// Shared constants and types for the TDM bearer/signalling serial port.
// Assumes: bearer channels are 8 bits wide, signalling fields 2 bits wide.
package tdm_pkg;
    localparam int BYTE_W  = 8;
    localparam int BIDX_W  = 3;   // log2(BYTE_W)
    localparam int DFLD_W  = 2;

    // Edge strobes derived from the oversampled bit clock, one core cycle wide.
    typedef struct packed {
        logic rise;    // launch point for receive data
        logic fall;    // sample point for transmit data
        logic frame;   // falling edge with the frame pulse high
    } tick_t;
endpackage

// File: rtl/tdm_bit_timer.sv
// Bit timer: detects the bit-clock edges in the core clock domain,
// registers the serial inputs alongside them, and keeps the bit
// position within the frame.
// Assumes: bit_clk, frame_sync, b_in and d_in are synchronous to clk
// and each bit-clock phase lasts at least two core cycles.
module tdm_bit_timer #(
    parameter int CNT_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_clk,
    input  logic               frame_sync,
    input  logic               b_in,
    input  logic               d_in,
    output tdm_pkg::tick_t     tick,
    output logic [CNT_W-1:0]   bit_pos,
    output logic               live,
    output logic               b_smp,
    output logic               d_smp
);
    logic bclk_q, bclk_qq, fs_q;

    // Register the bit clock and the inputs that belong to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            bclk_qq <= 1'b0;
            fs_q    <= 1'b0;
            b_smp   <= 1'b0;
            d_smp   <= 1'b0;
        end else begin
            bclk_q  <= bit_clk;
            bclk_qq <= bclk_q;
            fs_q    <= frame_sync;
            b_smp   <= b_in;
            d_smp   <= d_in;
        end
    end

    // Decode the edge strobes.
    always_comb begin
        tick.rise  = bclk_q & ~bclk_qq;
        tick.fall  = ~bclk_q & bclk_qq;
        tick.frame = tick.fall & fs_q;
    end

    // Advance the bit position; the frame pulse restarts it at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pos <= '0;
            live    <= 1'b0;
        end else if (tick.frame) begin
            bit_pos <= '0;
            live    <= 1'b1;
        end else if (tick.fall) begin
            bit_pos <= bit_pos + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_rx_launch.sv
// Receive launcher: latches the line-side receive data at the frame
// pulse and drives each channel's bits in its slot on rising edges.
// Assumes: SLOT_W + 3 >= CNT_W so every slot index is reachable.
// Lowest-numbered channel wins a shared slot.
module tdm_rx_launch #(
    parameter int N_LINES = 4,
    parameter int SLOT_W  = 8,
    parameter int CNT_W   = 9
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  tdm_pkg::tick_t                        tick,
    input  logic [CNT_W-1:0]                      bit_pos,
    input  logic                                  live,
    input  logic [N_LINES*2*SLOT_W-1:0]           b_slot_cfg,
    input  logic [N_LINES*2-1:0]                  b_en,
    input  logic [N_LINES*SLOT_W-1:0]             d_slot_cfg,
    input  logic [N_LINES-1:0]                    d_en,
    input  logic [N_LINES*2*tdm_pkg::BYTE_W-1:0]  line_rx_b,
    input  logic [N_LINES*tdm_pkg::DFLD_W-1:0]    line_rx_d,
    output logic                                  b_out,
    output logic                                  b_oe,
    output logic                                  b_slot_n,
    output logic                                  d_out,
    output logic                                  d_oe
);
    localparam int N_CH = 2 * N_LINES;
    localparam int BW   = tdm_pkg::BYTE_W;
    localparam int DW   = tdm_pkg::DFLD_W;

    logic [N_CH*BW-1:0]    rx_b_q;
    logic [N_LINES*DW-1:0] rx_d_q;
    logic [SLOT_W-1:0]     b_idx, d_idx;
    logic [N_CH-1:0]       b_hit, b_bitv;
    logic [N_LINES-1:0]    d_hit, d_bitv;
    logic                  b_any, b_sel, d_any, d_sel;

    // Slot index of the current bit for each bus.
    always_comb begin
        b_idx = SLOT_W'(bit_pos >> tdm_pkg::BIDX_W);
        d_idx = SLOT_W'(bit_pos >> 1);
    end

    // Latch one frame of receive data at the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_b_q <= '0;
            rx_d_q <= '0;
        end else if (tick.frame) begin
            rx_b_q <= line_rx_b;
            rx_d_q <= line_rx_d;
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_bch
        logic [BW-1:0] byte_q;
        assign byte_q = rx_b_q[g*BW +: BW];
        // Slot match and current bit for one bearer channel.
        always_comb begin
            b_hit[g]  = live && b_en[g] && (b_slot_cfg[g*SLOT_W +: SLOT_W] == b_idx);
            b_bitv[g] = byte_q[~bit_pos[tdm_pkg::BIDX_W-1:0]];
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_dln
        logic [DW-1:0] fld_q;
        assign fld_q = rx_d_q[g*DW +: DW];
        // Sub-slot match and current bit for one signalling field.
        always_comb begin
            d_hit[g]  = live && d_en[g] && (d_slot_cfg[g*SLOT_W +: SLOT_W] == d_idx);
            d_bitv[g] = fld_q[~bit_pos[0]];
        end
    end

    // Priority select: the lowest-numbered matching source is kept.
    always_comb begin
        b_any = 1'b0;
        b_sel = 1'b0;
        for (int c = N_CH - 1; c >= 0; c--) begin
            if (b_hit[c]) begin
                b_any = 1'b1;
                b_sel = b_bitv[c];
            end
        end
        d_any = 1'b0;
        d_sel = 1'b0;
        for (int l = N_LINES - 1; l >= 0; l--) begin
            if (d_hit[l]) begin
                d_any = 1'b1;
                d_sel = d_bitv[l];
            end
        end
    end

    // Launch the selected bits on the rising bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_out    <= 1'b0;
            b_oe     <= 1'b0;
            b_slot_n <= 1'b1;
            d_out    <= 1'b0;
            d_oe     <= 1'b0;
        end else if (tick.rise) begin
            b_out    <= b_sel;
            b_oe     <= b_any;
            b_slot_n <= ~b_any;
            d_out    <= d_sel;
            d_oe     <= d_any;
        end
    end
endmodule

// File: rtl/tdm_tx_capture.sv
// Transmit capture: samples the serial inputs on falling edges into
// per-channel collectors and publishes them at the frame pulse.
// Assumes: the last bit of a frame is sampled on the same edge
// that carries the frame pulse, so it is merged before publishing.
module tdm_tx_capture #(
    parameter int N_LINES = 4,
    parameter int SLOT_W  = 8,
    parameter int CNT_W   = 9
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  tdm_pkg::tick_t                        tick,
    input  logic [CNT_W-1:0]                      bit_pos,
    input  logic                                  live,
    input  logic                                  b_smp,
    input  logic                                  d_smp,
    input  logic [N_LINES*2*SLOT_W-1:0]           b_slot_cfg,
    input  logic [N_LINES*2-1:0]                  b_en,
    input  logic [N_LINES*SLOT_W-1:0]             d_slot_cfg,
    input  logic [N_LINES-1:0]                    d_en,
    output logic [N_LINES*2*tdm_pkg::BYTE_W-1:0]  line_tx_b,
    output logic [N_LINES*tdm_pkg::DFLD_W-1:0]    line_tx_d
);
    localparam int N_CH = 2 * N_LINES;
    localparam int BW   = tdm_pkg::BYTE_W;
    localparam int DW   = tdm_pkg::DFLD_W;

    logic [N_CH*BW-1:0]    cap_b_q, cap_b_nx;
    logic [N_LINES*DW-1:0] cap_d_q, cap_d_nx;
    logic [SLOT_W-1:0]     b_idx, d_idx;
    logic                  smp_ok;

    // Slot indices and the sampling qualifier.
    always_comb begin
        b_idx  = SLOT_W'(bit_pos >> tdm_pkg::BIDX_W);
        d_idx  = SLOT_W'(bit_pos >> 1);
        smp_ok = tick.fall && live;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_bch
        logic [BW-1:0] nx;
        // Next value of one bearer collector.
        always_comb begin
            nx = cap_b_q[g*BW +: BW];
            if (smp_ok && b_en[g] && (b_slot_cfg[g*SLOT_W +: SLOT_W] == b_idx))
                nx[~bit_pos[tdm_pkg::BIDX_W-1:0]] = b_smp;
        end
        assign cap_b_nx[g*BW +: BW] = nx;
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_dln
        logic [DW-1:0] nx;
        // Next value of one signalling collector.
        always_comb begin
            nx = cap_d_q[g*DW +: DW];
            if (smp_ok && d_en[g] && (d_slot_cfg[g*SLOT_W +: SLOT_W] == d_idx))
                nx[~bit_pos[0]] = d_smp;
        end
        assign cap_d_nx[g*DW +: DW] = nx;
    end

    // Hold the collectors and publish them at the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_b_q   <= '0;
            cap_d_q   <= '0;
            line_tx_b <= '0;
            line_tx_d <= '0;
        end else begin
            cap_b_q <= cap_b_nx;
            cap_d_q <= cap_d_nx;
            if (tick.frame) begin
                line_tx_b <= cap_b_nx;
                line_tx_d <= cap_d_nx;
            end
        end
    end
endmodule

// File: rtl/tdm_bd_port.sv
// Four-line TDM bearer/signalling serial port top level.
// Assumes: a static slot configuration and a core clock that runs
// at least four times faster than the bit clock.
module tdm_bd_port #(
    parameter int N_LINES = 4,
    parameter int SLOT_W  = 8,
    parameter int CNT_W   = 9
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bit_clk,
    input  logic                                  frame_sync,
    input  logic                                  b_in,
    input  logic                                  d_in,
    input  logic [N_LINES*2*SLOT_W-1:0]           b_slot_cfg,
    input  logic [N_LINES*2-1:0]                  b_en,
    input  logic [N_LINES*SLOT_W-1:0]             d_slot_cfg,
    input  logic [N_LINES-1:0]                    d_en,
    input  logic [N_LINES*2*tdm_pkg::BYTE_W-1:0]  line_rx_b,
    input  logic [N_LINES*tdm_pkg::DFLD_W-1:0]    line_rx_d,
    output logic [N_LINES*2*tdm_pkg::BYTE_W-1:0]  line_tx_b,
    output logic [N_LINES*tdm_pkg::DFLD_W-1:0]    line_tx_d,
    output logic                                  b_out,
    output logic                                  b_oe,
    output logic                                  b_slot_n,
    output logic                                  d_out,
    output logic                                  d_oe
);
    tdm_pkg::tick_t   tick;
    logic [CNT_W-1:0] bit_pos;
    logic             frame_live, frame_edge, b_smp, d_smp;

    assign frame_edge = tick.frame;

    tdm_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
        .b_in(b_in), .d_in(d_in), .tick(tick), .bit_pos(bit_pos),
        .live(frame_live), .b_smp(b_smp), .d_smp(d_smp)
    );

    tdm_rx_launch #(.N_LINES(N_LINES), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bit_pos(bit_pos), .live(frame_live),
        .b_slot_cfg(b_slot_cfg), .b_en(b_en), .d_slot_cfg(d_slot_cfg), .d_en(d_en),
        .line_rx_b(line_rx_b), .line_rx_d(line_rx_d),
        .b_out(b_out), .b_oe(b_oe), .b_slot_n(b_slot_n), .d_out(d_out), .d_oe(d_oe)
    );

    tdm_tx_capture #(.N_LINES(N_LINES), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bit_pos(bit_pos), .live(frame_live),
        .b_smp(b_smp), .d_smp(d_smp),
        .b_slot_cfg(b_slot_cfg), .b_en(b_en), .d_slot_cfg(d_slot_cfg), .d_en(d_en),
        .line_tx_b(line_tx_b), .line_tx_d(line_tx_d)
    );
endmodule

// File: rtl/tdm_bd_port_chk.sv
// Protocol checker for tdm_bd_port, attached with bind below.
// Assumes: the bound instance exposes frame_live and frame_edge.
module tdm_bd_port_chk #(
    parameter int N_LINES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bit_clk,
    input logic                      frame_live,
    input logic                      frame_edge,
    input logic                      b_out,
    input logic                      b_oe,
    input logic                      b_slot_n,
    input logic                      d_out,
    input logic                      d_oe,
    input logic [N_LINES*16-1:0]     line_tx_b,
    input logic [N_LINES*2-1:0]      line_tx_d
);
    // R2: no bus is driven before the first frame pulse.
    p_idle_unsynced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_live |-> (!b_oe && !d_oe));

    // R5: the slot indicator is low exactly while the bearer bus is driven.
    p_indicator_r5: assert property (@(posedge clk) disable iff (!rst_n)
        b_slot_n != b_oe);

    // R4: serial outputs change only after a bit-clock transition.
    p_launch_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_clk == $past(bit_clk) && $past(bit_clk) == $past(bit_clk, 2)
         && $past(bit_clk, 2) == $past(bit_clk, 3))
        |-> ($stable(b_oe) && $stable(b_out) && $stable(d_oe) && $stable(d_out)));

    // R7: published bearer bytes change only at a frame pulse.
    p_tx_b_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_tx_b) |-> $past(frame_edge));

    // R8: published signalling fields change only at a frame pulse.
    p_tx_d_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_tx_d) |-> $past(frame_edge));
endmodule

bind tdm_bd_port tdm_bd_port_chk #(.N_LINES(N_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk),
    .frame_live(frame_live), .frame_edge(frame_edge),
    .b_out(b_out), .b_oe(b_oe), .b_slot_n(b_slot_n),
    .d_out(d_out), .d_oe(d_oe),
    .line_tx_b(line_tx_b), .line_tx_d(line_tx_d)
);

// File: tb/tdm_bd_port_test.sv
// Directed bench for tdm_bd_port: one task per scenario.
module tdm_bd_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk = 1'b0;
    logic        frame_sync = 1'b0;
    logic        b_in = 1'b0;
    logic        d_in = 1'b0;
    logic [63:0] b_slot_cfg = '0;
    logic [7:0]  b_en = '0;
    logic [31:0] d_slot_cfg = '0;
    logic [3:0]  d_en = '0;
    logic [63:0] line_rx_b = '0;
    logic [7:0]  line_rx_d = '0;
    logic [63:0] line_tx_b;
    logic [7:0]  line_tx_d;
    logic        b_out, b_oe, b_slot_n, d_out, d_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    logic [63:0] rxb_cur = '0, exp_cap_b = '0, tx_pat_b = '0, swap_b = '0;
    logic [7:0]  rxd_cur = '0, exp_cap_d = '0, tx_pat_d = '0, swap_d = '0;
    bit          mdl_live = 0;
    bit          swap_mid = 0;

    always #2.5 clk = ~clk;

    tdm_bd_port uut (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
        .b_in(b_in), .d_in(d_in), .b_slot_cfg(b_slot_cfg), .b_en(b_en),
        .d_slot_cfg(d_slot_cfg), .d_en(d_en), .line_rx_b(line_rx_b),
        .line_rx_d(line_rx_d), .line_tx_b(line_tx_b), .line_tx_d(line_tx_d),
        .b_out(b_out), .b_oe(b_oe), .b_slot_n(b_slot_n), .d_out(d_out), .d_oe(d_oe)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int b_owner(int p);
        for (int c = 0; c < 8; c++)
            if (b_en[c] && b_slot_cfg[c*8 +: 8] == 8'(p / 8)) return c;
        return -1;
    endfunction

    function automatic int d_owner(int p);
        for (int l = 0; l < 4; l++)
            if (d_en[l] && d_slot_cfg[l*8 +: 8] == 8'(p / 2)) return l;
        return -1;
    endfunction

    // One bit period: high phase, sample outputs, low phase.
    task automatic run_frame(int nbits, string tb, string td, string ttb, string ttd);
        for (int p = 0; p < nbits; p++) begin
            int   ob, od;
            logic bv, dv, eb, ed;
            ob = b_owner(p);
            od = d_owner(p);
            bv = (ob >= 0) ? tx_pat_b[ob*8 + 7 - (p % 8)] : (p % 2 == 1);
            dv = (od >= 0) ? tx_pat_d[od*2 + 1 - (p % 2)] : (p % 3 == 0);
            if (swap_mid && p == nbits / 2) begin
                line_rx_b = swap_b;
                line_rx_d = swap_d;
            end
            @(negedge clk);
            bit_clk = 1'b1;
            frame_sync = (p == nbits - 1);
            b_in = bv;
            d_in = dv;
            repeat (4) @(negedge clk);
            if (mdl_live && ob >= 0) begin
                eb = rxb_cur[ob*8 + 7 - (p % 8)];
                chk(b_oe && !b_slot_n && b_out == eb, tb, $sformatf("B bit %0d", p),
                    {61'd0, b_oe, b_slot_n, b_out}, {61'd0, 1'b1, 1'b0, eb});
            end else begin
                chk(!b_oe && b_slot_n, mdl_live ? "R5" : "R2", $sformatf("B idle bit %0d", p),
                    {62'd0, b_oe, b_slot_n}, {62'd0, 1'b0, 1'b1});
            end
            if (mdl_live && od >= 0) begin
                ed = rxd_cur[od*2 + 1 - (p % 2)];
                chk(d_oe && d_out == ed, td, $sformatf("D bit %0d", p),
                    {62'd0, d_oe, d_out}, {62'd0, 1'b1, ed});
            end else begin
                chk(!d_oe, mdl_live ? "R6" : "R2", $sformatf("D idle bit %0d", p),
                    {63'd0, d_oe}, 64'd0);
            end
            if (mdl_live) begin
                for (int c = 0; c < 8; c++)
                    if (b_en[c] && b_slot_cfg[c*8 +: 8] == 8'(p / 8))
                        exp_cap_b[c*8 + 7 - (p % 8)] = bv;
                for (int l = 0; l < 4; l++)
                    if (d_en[l] && d_slot_cfg[l*8 +: 8] == 8'(p / 2))
                        exp_cap_d[l*2 + 1 - (p % 2)] = dv;
            end
            bit_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        frame_sync = 1'b0;
        chk(line_tx_b == exp_cap_b, ttb, "line_tx_b", line_tx_b, exp_cap_b);
        chk(line_tx_d == exp_cap_d, ttd, "line_tx_d", {56'd0, line_tx_d}, {56'd0, exp_cap_d});
        rxb_cur  = line_rx_b;
        rxd_cur  = line_rx_d;
        mdl_live = 1;
        swap_mid = 0;
    endtask

    // R1 and R2: reset values, then an unsynced frame with nothing driven.
    task automatic t_reset;
        chk(!b_oe && b_slot_n && !d_oe, "R1", "outputs after reset",
            {61'd0, b_oe, b_slot_n, d_oe}, {61'd0, 3'b010});
        chk(line_tx_b == '0 && line_tx_d == '0, "R1", "line_tx after reset",
            line_tx_b | {56'd0, line_tx_d}, 64'd0);
        b_slot_cfg = {8'd50, 8'd40, 8'd9, 8'd7, 8'd1, 8'd2, 8'd0, 8'd3};
        b_en       = 8'hFF;
        d_slot_cfg = {8'd9, 8'd7, 8'd0, 8'd15};
        d_en       = 4'hF;
        line_rx_b  = 64'hA5C3_0F96_5A3C_E187;
        line_rx_d  = 8'b10_01_11_10;
        tx_pat_b   = 64'h1122_3344_D2B4_6C0F;
        tx_pat_d   = 8'b01_10_11_01;
        run_frame(32, "R2", "R2", "R2", "R2");
    endtask

    // R4, R6, R7, R8: 32-bit frame with slots at both frame ends.
    task automatic t_frame32;
        run_frame(32, "R4", "R6", "R7", "R8");
        tx_pat_b = 64'h0000_0000_3C81_F00D;
        tx_pat_d = 8'b11_00_10_01;
        run_frame(32, "R4", "R6", "R7", "R8");
    endtask

    // R3: change to a 256-bit frame with scattered slots.
    task automatic t_frame256;
        b_slot_cfg = {8'd12, 8'd2, 8'd30, 8'd9, 8'd17, 8'd0, 8'd5, 8'd31};
        d_slot_cfg = {8'd64, 8'd0, 8'd3, 8'd127};
        line_rx_b  = 64'h0123_4567_89AB_CDEF;
        line_rx_d  = 8'b00_11_01_10;
        tx_pat_b   = 64'hFEDC_BA98_7654_3210;
        tx_pat_d   = 8'b10_01_00_11;
        run_frame(256, "R3", "R3", "R3", "R3");
        run_frame(256, "R3", "R3", "R7", "R8");
        run_frame(32, "R3", "R3", "R3", "R3");
    endtask

    // R10: two channels and two lines share one slot.
    task automatic t_conflict;
        b_slot_cfg = {8'd60, 8'd60, 8'd60, 8'd60, 8'd3, 8'd0, 8'd1, 8'd1};
        d_slot_cfg = {8'd15, 8'd0, 8'd4, 8'd4};
        line_rx_b  = 64'h0000_0000_7E81_C33C;
        line_rx_d  = 8'b00_01_10_01;
        tx_pat_b   = 64'h0000_0000_55AA_E718;
        tx_pat_d   = 8'b00_00_01_10;
        run_frame(32, "R10", "R10", "R10", "R10");
        run_frame(32, "R10", "R10", "R10", "R10");
    endtask

    // R11: disabled channels neither drive nor capture.
    task automatic t_disabled;
        b_slot_cfg = {8'd60, 8'd60, 8'd60, 8'd60, 8'd3, 8'd2, 8'd1, 8'd0};
        d_slot_cfg = {8'd12, 8'd8, 8'd4, 8'd0};
        b_en       = 8'b1010_0101;
        d_en       = 4'b0101;
        tx_pat_b   = 64'hFFFF_FFFF_9966_33CC;
        tx_pat_d   = 8'b11_11_00_11;
        run_frame(32, "R11", "R11", "R11", "R11");
        run_frame(32, "R11", "R11", "R11", "R11");
        b_en = 8'hFF;
        d_en = 4'hF;
    endtask

    // R9: receive data rewritten mid-frame only shows in the next frame.
    task automatic t_latch;
        swap_b   = 64'hDEAD_BEEF_F00D_CAFE;
        swap_d   = 8'b01_10_01_10;
        swap_mid = 1;
        run_frame(32, "R9", "R9", "R7", "R8");
        run_frame(32, "R9", "R9", "R7", "R8");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_frame32;
        t_frame256;
        t_conflict;
        t_disabled;
        t_latch;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired act=%h exp=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule